// File: doc/BRIEF.md
# Fractional-Rate Timebase with Alarm

This block keeps a 64-bit time count for a graphics controller and raises an alarm interrupt once the count reaches a programmed compare value. The count does not advance by a fixed prescaler. Each clock, a 16-bit rate numerator is added into a small remainder accumulator. The accumulator is then divided by a 16-bit rate denominator. The quotient is added to the time, and the remainder is kept for the next clock. Over a long run the time therefore advances by numerator/denominator counts per clock, and the ratio may be below or above one.

Software reaches the block through a plain 32-bit register port. The port takes a word address and a single-cycle request strobe, with a write flag. The alarm has a sticky status bit that is cleared by writing a one, and an enable bit. The interrupt output is the level of the status bit gated by the enable bit.

Top module: `frac_timer`

## Requirements
- R1: Registers sit at word addresses (byte offset / 4) 0x040 status, 0x050 enable, 0x080 numerator, 0x084 denominator, 0x100 time bits 31:0, 0x104 time bits 63:32, 0x108 alarm; reads elsewhere return 0 and writes elsewhere change nothing.
- R2: After reset the time, alarm and enable are 0 and numerator and denominator are 1; because time 0 is not below alarm 0, the status bit reads 1 after the first clock.
- R3: Numerator and denominator keep write bits 15:0 only; bits 31:16 read back as zero.
- R4: A write of zero to the denominator stores 1.
- R5: A time write clears the remainder; W clocks after that write the time equals floor(W*N/D) above the written value, for numerator N and denominator D.
- R6: While the numerator is zero the time does not move.
- R7: Writes to either time word or the alarm drop data bits 4:0 (they store as zero); a time write replaces only its own half of the count.
- R8: The enable register keeps only bit 0; other bits read as zero.
- R9: Status bit 0 becomes 1 on the clock after the 64-bit time is at or above the zero-extended alarm; writing 1 to bit 0 clears it at that edge, writing 0 leaves it, and it sets again one clock later if the condition still holds.
- R10: irq is high exactly while status bit 0 and enable bit 0 are both 1.
- R11: Read data is registered: it shows the register value from before the edge that sampled the read strobe, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Alarm interrupt, level |

## Verification
A register write takes effect at the edge that samples the strobe. A read returns state from before its own edge, so a read issued W idle clocks after a time write returns the time after exactly W increments. The bench drives and samples on the falling edge and counts every rising edge between the stimulus and the sample. The alarm test places the alarm 64 counts ahead at unit rate. It then checks that irq is still low after the 64th edge and high after the 65th. The re-set after a clear is checked one edge after the clearing write.

// File: rtl/frac_timer.sv
module frac_timer #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int FRAC_W   = 16,
  parameter int LOW_DROP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int TIME_W = 2 * DATA_W;
  localparam int ACC_W  = FRAC_W + 1;
  localparam logic [DATA_W-1:0] KEEP = {DATA_W{1'b1}} << LOW_DROP;

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h040);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'('h050);
  localparam logic [ADDR_W-1:0] A_NUM  = ADDR_W'('h080);
  localparam logic [ADDR_W-1:0] A_DEN  = ADDR_W'('h084);
  localparam logic [ADDR_W-1:0] A_TLO  = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] A_THI  = ADDR_W'('h104);
  localparam logic [ADDR_W-1:0] A_ALM  = ADDR_W'('h108);

  logic [FRAC_W-1:0] num_q, den_q;
  logic [ACC_W-1:0]  acc_q;
  logic [TIME_W-1:0] time_q;
  logic [DATA_W-1:0] alarm_q;
  logic              stat_q, en_q;

  wire wr      = bus_req & bus_we;
  wire rd      = bus_req & ~bus_we;
  wire wr_stat = wr && bus_addr == A_STAT;
  wire wr_en   = wr && bus_addr == A_EN;
  wire wr_num  = wr && bus_addr == A_NUM;
  wire wr_den  = wr && bus_addr == A_DEN;
  wire wr_tlo  = wr && bus_addr == A_TLO;
  wire wr_thi  = wr && bus_addr == A_THI;
  wire wr_alm  = wr && bus_addr == A_ALM;

  wire [ACC_W-1:0] sum   = acc_q + ACC_W'(num_q);
  wire [ACC_W-1:0] steps = sum / ACC_W'(den_q);
  wire [ACC_W-1:0] rem   = sum % ACC_W'(den_q);
  wire             run   = (num_q != '0) && (den_q != '0);
  wire             hit   = time_q >= TIME_W'(alarm_q);
  wire             clr   = wr_stat && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      acc_q  <= '0;
    end else if (wr_tlo) begin
      time_q[DATA_W-1:0] <= bus_wdata & KEEP;
      acc_q              <= '0;
    end else if (wr_thi) begin
      time_q[TIME_W-1:DATA_W] <= bus_wdata & KEEP;
      acc_q                   <= '0;
    end else if (run) begin
      time_q <= time_q + TIME_W'(steps);
      acc_q  <= rem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q   <= FRAC_W'(1);
      den_q   <= FRAC_W'(1);
      alarm_q <= '0;
      en_q    <= 1'b0;
    end else begin
      if (wr_num) num_q <= bus_wdata[FRAC_W-1:0];
      if (wr_den) den_q <= (bus_wdata[FRAC_W-1:0] == '0) ? FRAC_W'(1) : bus_wdata[FRAC_W-1:0];
      if (wr_alm) alarm_q <= bus_wdata & KEEP;
      if (wr_en)  en_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat_q <= 1'b0;
    else if (clr) stat_q <= 1'b0;
    else if (hit) stat_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd) begin
      case (bus_addr)
        A_STAT:  bus_rdata <= DATA_W'(stat_q);
        A_EN:    bus_rdata <= DATA_W'(en_q);
        A_NUM:   bus_rdata <= DATA_W'(num_q);
        A_DEN:   bus_rdata <= DATA_W'(den_q);
        A_TLO:   bus_rdata <= time_q[DATA_W-1:0];
        A_THI:   bus_rdata <= time_q[TIME_W-1:DATA_W];
        A_ALM:   bus_rdata <= alarm_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign irq = stat_q & en_q;

  AST_DEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    den_q != '0); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (num_q == '0 && !wr_tlo && !wr_thi) |=> $stable(time_q)); // R6
  AST_TIME_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_tlo && !wr_thi) |=> time_q >= $past(time_q)); // R5
  AST_ALARM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> stat_q); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !stat_q); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> !irq); // R10
endmodule

// File: tb/sim_frac_timer.sv
module sim_frac_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  frac_timer u0 (.clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
                 .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int nl[7] = '{0, 1, 2, 3, 5, 7, 16};
    int dl[6] = '{1, 2, 3, 7, 16, 0};
    int wl[4] = '{0, 5, 13, 37};
    idle(2);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    rd(10'h080, v); check("R2 num", v, 1);
    rd(10'h084, v); check("R2 den", v, 1);
    rd(10'h050, v); check("R2 en", v, 0);
    rd(10'h108, v); check("R2 alarm", v, 0);
    rd(10'h040, v); check("R2 status", v, 1);
    check("R2 irq", {31'b0, irq}, 0);
    // R3 / R4 / R8 / R1
    wr(10'h080, 32'h0012_3456); rd(10'h080, v); check("R3 num mask", v, 32'h3456);
    wr(10'h084, 32'hABCD_0007); rd(10'h084, v); check("R3 den mask", v, 32'h0007);
    wr(10'h084, 32'h0001_0000); rd(10'h084, v); check("R4 den zero", v, 1);
    wr(10'h050, 32'hFFFF_FFFE); rd(10'h050, v); check("R8 en bit0", v, 0);
    wr(10'h050, 32'hFFFF_FFFF); rd(10'h050, v); check("R8 en", v, 1);
    wr(10'h051, 32'h0); rd(10'h050, v); check("R1 unmapped write", v, 1);
    wr(10'h041, 32'hFFFF_FFFF); rd(10'h040, v); check("R1 unmapped write status", v, 1);
    rd(10'h041, v); check("R1 unmapped read", v, 0);
    wr(10'h050, 32'h0);
    // R6 / R7 with frozen time
    wr(10'h080, 32'h0);
    wr(10'h104, 32'h1234_5678);
    wr(10'h100, 32'hABCD_EF1F);
    idle(20);
    rd(10'h100, v); check("R7/R6 time low", v, 32'hABCD_EF00);
    rd(10'h104, v); check("R7 time high", v, 32'h1234_5660);
    wr(10'h104, 32'h0);
    rd(10'h100, v); check("R7 low kept on high write", v, 32'hABCD_EF00);
    wr(10'h108, 32'hFFFF_FFFF); rd(10'h108, v); check("R7 alarm mask", v, 32'hFFFF_FFE0);
    // R11: rdata holds until next read
    idle(3); check("R11 hold", bus_rdata, 32'hFFFF_FFE0);
    // R5 rate sweep
    foreach (nl[i]) foreach (dl[j]) begin
      wr(10'h080, nl[i]);
      wr(10'h084, dl[j]);
      foreach (wl[k]) begin
        int de;
        de = (dl[j] == 0) ? 1 : dl[j];
        wr(10'h104, 32'h0);
        wr(10'h100, 32'h0);
        idle(wl[k]);
        rd(10'h100, v);
        check(nl[i] == 0 ? "R6 zero rate" : "R5 rate", v, (wl[k] * nl[i]) / de);
      end
    end
    // R9 / R10 alarm timing
    wr(10'h080, 1); wr(10'h084, 1);
    wr(10'h050, 1);
    wr(10'h104, 0); wr(10'h100, 0);
    wr(10'h108, 32'h40);
    wr(10'h040, 1);
    idle(62);
    check("R10 irq before alarm", {31'b0, irq}, 0);
    idle(1);
    check("R9/R10 irq at alarm", {31'b0, irq}, 1);
    wr(10'h040, 0);
    rd(10'h040, v); check("R9 write zero keeps", v, 1);
    wr(10'h040, 1);
    check("R9 clear", {31'b0, irq}, 0);
    idle(1);
    check("R9 re-set", {31'b0, irq}, 1);
    wr(10'h050, 0);
    check("R10 masked", {31'b0, irq}, 0);
    rd(10'h040, v); check("R9 status while masked", v, 1);
    // alarm compare against 64-bit time with high word set
    wr(10'h108, 32'hFFFF_FFE0); wr(10'h040, 1);
    rd(10'h040, v); check("R9 below alarm", v, 0);
    wr(10'h104, 32'h20);
    idle(1);
    rd(10'h040, v); check("R9 high word above alarm", v, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule